// File: doc/BRIEF.md
# Deep Sleep Pad Retention Controller

This block keeps the pads of a chip frozen across a deep low-power period and the wake-up that follows it. When the deep-sleep entry pulse arrives, it copies the per-pin direction and output-latch settings into a snapshot. It sets a sticky freeze bit, and from then on the pads are driven from that snapshot. Software may rewrite the direction, latch and oscillator-enable settings after waking, but none of those writes reaches the pads or the oscillator until software clears the freeze bit. Once the freeze bit is clear, the pads follow the live settings again.

Each reset cause acts on the block in its own way. A power-on or deep-sleep brown-out event releases the pins at once and wipes the two retained general-purpose registers and the retained oscillator enable. An external master reset leaves the freeze bit, the retained registers and the oscillator enable untouched, but sends the pins to their reset state (high-impedance). Two status flags, one for deep-sleep entry and one for power-on, are decoded into a reset-cause code that boot software reads.

Top module: `dsio_retain`

## Requirements
- R1: While `por_evt` is high, and in the cycle after it falls, the block is in this state: `release_o`=0, `gp0_o`=`gp1_o`=0, `porflag_o`=1. The retained oscillator enable is cleared, and the pads follow `cfg_dir`/`cfg_lat`.
- R2: On a `ds_enter` pulse, `release_o` and `dsflag_o` become 1 at the next edge. `cfg_dir` (1 = drive) and `cfg_lat` are captured into the snapshot. Until the block is released, `pad_oe`/`pad_out` show the snapshot and not the live settings.
- R3: A write to the release bit with data 1 (`rel_wr`=1, `rel_wdata`=1) is ignored: a frozen block stays frozen with unchanged pads, and a released block is not frozen by it.
- R4: A write with data 0 clears `release_o` at the next edge. From then on `pad_oe`/`pad_out` equal the current `cfg_dir`/`cfg_lat`.
- R5: While frozen, `osc_en_o` keeps the value it had at entry, whatever `osc_en_req` does. After release it follows `osc_en_req`. Software therefore keeps the oscillator running by setting the request before releasing.
- R6: A `mclr_evt` pulse while frozen leaves `release_o`=1, the retained registers, `osc_en_o` and `dsflag_o` unchanged, and forces `pad_oe`=0 and `pad_out`=0.
- R7: A `por_evt` pulse while frozen releases the pins and clears the retained registers. It keeps `dsflag_o`=1 and sets `porflag_o`. A `por_evt` while not frozen clears `dsflag_o`.
- R8: `dsflag_o` is cleared only by `flag_clr[0]` and `porflag_o` only by `flag_clr[1]`. The only other route is R7's power-on while not frozen, which clears `dsflag_o`. `cause_o` encodes {ds,por}: 0 = both clear (other reset), 1 = only power-on (normal power-up), 2 = both set (deep sleep, power lost, exit), 3 = only deep-sleep (plain wake).
- R9: `gp_we[0]`/`gp_we[1]` load `gp_wdata` into `gp0_o`/`gp1_o` at the next edge. The values survive deep-sleep entry and master reset.
- R10: A `ds_enter` and a release-clear write in the same cycle leave the block frozen: entry wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| por_evt | input | 1 | Power-on or deep-sleep brown-out event, synchronous |
| mclr_evt | input | 1 | External master reset pulse |
| ds_enter | input | 1 | Deep-sleep entry pulse |
| cfg_dir | input | NPIN | Live direction settings, 1 = output |
| cfg_lat | input | NPIN | Live output latch settings |
| rel_wr | input | 1 | Software write strobe to the release bit |
| rel_wdata | input | 1 | Data written to the release bit |
| osc_en_req | input | 1 | Software secondary-oscillator enable setting |
| gp_we | input | 2 | Write enables for the two retained registers |
| gp_wdata | input | GPW | Write data for the retained registers |
| flag_clr | input | 2 | Clear strobes: bit 0 deep-sleep flag, bit 1 power-on flag |
| pad_oe | output | NPIN | Pad output enables |
| pad_out | output | NPIN | Pad output values |
| release_o | output | 1 | Freeze (release) bit |
| osc_en_o | output | 1 | Effective oscillator enable |
| gp0_o | output | GPW | Retained register 0 |
| gp1_o | output | GPW | Retained register 1 |
| dsflag_o | output | 1 | Deep-sleep status flag |
| porflag_o | output | 1 | Power-on status flag |
| cause_o | output | 2 | Decoded reset cause |

## Verification
The bench changes `cfg_dir`/`cfg_lat` and `osc_en_req` while frozen. A design that leaks live settings to the pads or the oscillator shows the new values too early. It writes a 1 to the release bit, which a level-style bit would misread as a clear. It issues a master reset mid-freeze: a design that treats this like power-on drops the freeze and the retained registers. A design that ignores it keeps driving the snapshot. It also issues a power-on mid-freeze, where a wrong design keeps the pins frozen or loses the deep-sleep flag, and so decodes the wrong cause. It also puts entry and release-clear in the same cycle, where wrong priority leaves the pads unfrozen.

// File: rtl/dsio_retain.sv
module dsio_retain #(
  parameter int NPIN = 8,
  parameter int GPW  = 16
) (
  input  logic            clk,
  input  logic            por_evt,
  input  logic            mclr_evt,
  input  logic            ds_enter,
  input  logic [NPIN-1:0] cfg_dir,
  input  logic [NPIN-1:0] cfg_lat,
  input  logic            rel_wr,
  input  logic            rel_wdata,
  input  logic            osc_en_req,
  input  logic [1:0]      gp_we,
  input  logic [GPW-1:0]  gp_wdata,
  input  logic [1:0]      flag_clr,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pad_out,
  output logic            release_o,
  output logic            osc_en_o,
  output logic [GPW-1:0]  gp0_o,
  output logic [GPW-1:0]  gp1_o,
  output logic            dsflag_o,
  output logic            porflag_o,
  output logic [1:0]      cause_o
);

  localparam logic [1:0] CAUSE_OTHER = 2'd0;
  localparam logic [1:0] CAUSE_PWRUP = 2'd1;
  localparam logic [1:0] CAUSE_LOST  = 2'd2;
  localparam logic [1:0] CAUSE_WAKE  = 2'd3;

  logic            frz;
  logic [NPIN-1:0] snap_dir, snap_lat;
  logic            osc_hold;
  logic            rel_clr;

  assign rel_clr   = rel_wr && !rel_wdata;
  assign release_o = frz;
  assign pad_oe    = frz ? snap_dir : cfg_dir;
  assign pad_out   = frz ? snap_lat : cfg_lat;
  assign osc_en_o  = frz ? osc_hold : osc_en_req;

  always_ff @(posedge clk) begin
    if (por_evt) begin
      frz       <= 1'b0;
      snap_dir  <= '0;
      snap_lat  <= '0;
      osc_hold  <= 1'b0;
      gp0_o     <= '0;
      gp1_o     <= '0;
      porflag_o <= 1'b1;
      if (!frz) dsflag_o <= 1'b0;
    end else begin
      if (mclr_evt) begin
        snap_dir <= '0;
        snap_lat <= '0;
      end else if (ds_enter) begin
        frz      <= 1'b1;
        snap_dir <= cfg_dir;
        snap_lat <= cfg_lat;
        osc_hold <= osc_en_o;
      end else if (rel_clr) begin
        frz <= 1'b0;
      end

      if (!mclr_evt && gp_we[0]) gp0_o <= gp_wdata;
      if (!mclr_evt && gp_we[1]) gp1_o <= gp_wdata;

      if (ds_enter && !mclr_evt) dsflag_o <= 1'b1;
      else if (flag_clr[0])      dsflag_o <= 1'b0;

      if (flag_clr[1]) porflag_o <= 1'b0;
    end
  end

  always_comb begin
    unique case ({dsflag_o, porflag_o})
      2'b00:   cause_o = CAUSE_OTHER;
      2'b01:   cause_o = CAUSE_PWRUP;
      2'b11:   cause_o = CAUSE_LOST;
      default: cause_o = CAUSE_WAKE;
    endcase
  end

  // R1
  por_clears_chk: assert property (@(posedge clk)
    por_evt |=> (!release_o && porflag_o && gp0_o == '0 && gp1_o == '0));

  // R2
  entry_sets_chk: assert property (@(posedge clk) disable iff (por_evt)
    (ds_enter && !mclr_evt) |=> (release_o && dsflag_o));

  // R3
  no_self_freeze_chk: assert property (@(posedge clk) disable iff (por_evt)
    (!release_o && !ds_enter) |=> !release_o);

  // R5
  osc_frozen_chk: assert property (@(posedge clk) disable iff (por_evt)
    (release_o && !ds_enter && !rel_clr) |=> $stable(osc_en_o));

  // R6
  mclr_keep_chk: assert property (@(posedge clk) disable iff (por_evt)
    (mclr_evt && release_o) |=> (release_o && pad_oe == '0 && pad_out == '0));

  // R8
  dsflag_sticky_chk: assert property (@(posedge clk) disable iff (por_evt)
    (dsflag_o && !flag_clr[0]) |=> dsflag_o);

  // R10
  entry_wins_chk: assert property (@(posedge clk) disable iff (por_evt)
    (ds_enter && rel_clr && !mclr_evt) |=> release_o);

endmodule

// File: tb/dsio_retain_test.sv
module dsio_retain_test;
  localparam int NPIN = 8;
  localparam int GPW  = 16;

  logic            clk = 1'b0;
  logic            por_evt = 1'b1;
  logic            mclr_evt = 1'b0;
  logic            ds_enter = 1'b0;
  logic [NPIN-1:0] cfg_dir = '0;
  logic [NPIN-1:0] cfg_lat = '0;
  logic            rel_wr = 1'b0;
  logic            rel_wdata = 1'b0;
  logic            osc_en_req = 1'b0;
  logic [1:0]      gp_we = '0;
  logic [GPW-1:0]  gp_wdata = '0;
  logic [1:0]      flag_clr = '0;
  logic [NPIN-1:0] pad_oe, pad_out;
  logic            release_o, osc_en_o, dsflag_o, porflag_o;
  logic [GPW-1:0]  gp0_o, gp1_o;
  logic [1:0]      cause_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dsio_retain #(.NPIN(NPIN), .GPW(GPW)) uut (
    .clk(clk), .por_evt(por_evt), .mclr_evt(mclr_evt), .ds_enter(ds_enter),
    .cfg_dir(cfg_dir), .cfg_lat(cfg_lat), .rel_wr(rel_wr), .rel_wdata(rel_wdata),
    .osc_en_req(osc_en_req), .gp_we(gp_we), .gp_wdata(gp_wdata), .flag_clr(flag_clr),
    .pad_oe(pad_oe), .pad_out(pad_out), .release_o(release_o), .osc_en_o(osc_en_o),
    .gp0_o(gp0_o), .gp1_o(gp1_o), .dsflag_o(dsflag_o), .porflag_o(porflag_o),
    .cause_o(cause_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic enter(input logic [NPIN-1:0] d, input logic [NPIN-1:0] l);
    cfg_dir = d; cfg_lat = l; ds_enter = 1'b1;
    tick();
    ds_enter = 1'b0;
  endtask

  task automatic rel_write(input logic v);
    rel_wr = 1'b1; rel_wdata = v;
    tick();
    rel_wr = 1'b0; rel_wdata = 1'b0;
  endtask

  task automatic t_reset();
    por_evt = 1'b1;
    cfg_dir = 8'h0F; cfg_lat = 8'h05;
    repeat (3) tick();
    por_evt = 1'b0;
    tick();
    chk("R1 release", release_o, 0);
    chk("R1 gp0", gp0_o, 0);
    chk("R1 gp1", gp1_o, 0);
    chk("R1 porflag", porflag_o, 1);
    chk("R1 pad_oe live", pad_oe, 8'h0F);
    chk("R1 pad_out live", pad_out, 8'h05);
    chk("R8 cause powerup", cause_o, 1);
  endtask

  task automatic t_gp();
    gp_we = 2'b01; gp_wdata = 16'h1234; tick();
    gp_we = 2'b10; gp_wdata = 16'hBEEF; tick();
    gp_we = 2'b00;
    chk("R9 gp0", gp0_o, 16'h1234);
    chk("R9 gp1", gp1_o, 16'hBEEF);
  endtask

  task automatic t_entry_freeze();
    osc_en_req = 1'b1;
    enter(8'hA5, 8'h3C);
    chk("R2 release", release_o, 1);
    chk("R2 dsflag", dsflag_o, 1);
    cfg_dir = 8'h00; cfg_lat = 8'hFF; osc_en_req = 1'b0;
    tick();
    chk("R2 pad_oe frozen", pad_oe, 8'hA5);
    chk("R2 pad_out frozen", pad_out, 8'h3C);
    chk("R5 osc held", osc_en_o, 1);
    chk("R9 gp0 kept", gp0_o, 16'h1234);
    rel_write(1'b1);
    chk("R3 still frozen", release_o, 1);
    chk("R3 pads unchanged", pad_oe, 8'hA5);
    rel_write(1'b0);
    chk("R4 released", release_o, 0);
    chk("R4 pad_oe live", pad_oe, 8'h00);
    chk("R4 pad_out live", pad_out, 8'hFF);
    chk("R5 osc follows req", osc_en_o, 0);
    rel_write(1'b1);
    chk("R3 write one no freeze", release_o, 0);
  endtask

  task automatic t_osc_keep();
    osc_en_req = 1'b1;
    enter(8'h11, 8'h01);
    osc_en_req = 1'b0; tick();
    chk("R5 frozen osc", osc_en_o, 1);
    osc_en_req = 1'b1; tick();
    rel_write(1'b0);
    chk("R5 osc kept on", osc_en_o, 1);
  endtask

  task automatic t_mclr();
    osc_en_req = 1'b1;
    enter(8'hC3, 8'h81);
    osc_en_req = 1'b0;
    mclr_evt = 1'b1; gp_we = 2'b01; gp_wdata = 16'h0BAD;
    tick();
    mclr_evt = 1'b0; gp_we = 2'b00;
    chk("R6 release kept", release_o, 1);
    chk("R6 pad_oe reset", pad_oe, 0);
    chk("R6 pad_out reset", pad_out, 0);
    chk("R6 gp0 kept", gp0_o, 16'h1234);
    chk("R6 osc kept", osc_en_o, 1);
    chk("R6 dsflag kept", dsflag_o, 1);
    rel_write(1'b0);
  endtask

  task automatic t_flags_and_por();
    flag_clr = 2'b11; tick(); flag_clr = 2'b00;
    chk("R8 cause other", cause_o, 0);
    enter(8'h5A, 8'h0A);
    chk("R8 cause wake", cause_o, 3);
    tick();
    chk("R8 dsflag sticky", dsflag_o, 1);
    cfg_dir = 8'h77; cfg_lat = 8'h66;
    por_evt = 1'b1; tick(); por_evt = 1'b0;
    chk("R7 released", release_o, 0);
    chk("R7 pads live", pad_oe, 8'h77);
    chk("R7 gp0 cleared", gp0_o, 0);
    chk("R7 gp1 cleared", gp1_o, 0);
    chk("R7 dsflag kept", dsflag_o, 1);
    chk("R8 cause lost power", cause_o, 2);
    flag_clr = 2'b01; tick(); flag_clr = 2'b00;
    chk("R8 ds clear only", cause_o, 1);
    flag_clr = 2'b10; tick(); flag_clr = 2'b00;
    enter(8'h01, 8'h01);
    rel_write(1'b0);
    por_evt = 1'b1; tick(); por_evt = 1'b0;
    chk("R7 por awake clears dsflag", dsflag_o, 0);
  endtask

  task automatic t_priority();
    cfg_dir = 8'h3F; cfg_lat = 8'h2A;
    ds_enter = 1'b1; rel_wr = 1'b1; rel_wdata = 1'b0;
    tick();
    ds_enter = 1'b0; rel_wr = 1'b0;
    cfg_dir = 8'h00; tick();
    chk("R10 entry wins", release_o, 1);
    chk("R10 pads frozen", pad_oe, 8'h3F);
    rel_write(1'b0);
  endtask

  initial begin
    t_reset();
    t_gp();
    t_entry_freeze();
    t_osc_keep();
    t_mclr();
    t_flags_and_por();
    t_priority();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule